// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Counter Core

This block is the counting engine of a general-purpose timer. A single 16-bit register counts up or down, and a mode field sets how it does so. The modes are free-running, pulse-width measurement with capture-and-clear, external event counting, encoder-driven compare counting, and triangular up/down counting. Edge detection, filtering and any register access are handled by logic around the block. That logic passes in single-cycle strobes and level conditions, and it reads back the count, the captured value, two event pulses and two sticky overflow flags.

Counting runs while the enable input is high, and the rising edge of enable starts a run. The start value depends on the mode. Clears take priority over counting. The wrap from the all-ones value to zero is treated as an overflow in only some modes, and it is suppressed on the first step after a start. A clear is never counted as an overflow.

Top module: `multimode_tmr16`

## Requirements
- R1: While reset is active and right after it is released, the count, the captured value, both pulses and both sticky flags are zero.
- R2: In free-running mode (code 0) and pulse-width mode (code 1), the rising edge of enable loads 0xFFFF and the count then rises by one every cycle, so the first step wraps to 0x0000. Codes 5 to 7 behave as code 0.
- R3: In modes 0 and 1, an up step from 0xFFFF to 0x0000 pulses the overflow output for one cycle and sets the general sticky flag. In encoder mode the same step pulses the overflow output and sets the encoder sticky flag. The first step after a start never counts as an overflow.
- R4: In modes 0, 2 and 3 with compare-clear enabled, a count equal to the compare value is cleared to zero on the next edge and the match output pulses for one cycle. This clear does not count as an overflow, even when the match is at 0xFFFF.
- R5: In pulse-width mode, a capture strobe copies the current count to the captured output and clears the count. A capture at 0xFFFF gives no overflow pulse.
- R6: In event-count mode (code 2), the rising edge of enable loads 0x0000. After that the count rises by one only in cycles where the event strobe is high.
- R7: In encoder mode (code 3), an up strobe adds one and a down strobe subtracts one, and both together or neither leaves the count unchanged. At start the count loads the reload value when the load select is 0 and is left as it was when the load select is 1. The encoder clear strobe clears the count.
- R8: In triangular mode (code 4), the count rises until it equals the compare value (which must be nonzero), then falls to 0x0000, then rises again. This mode never produces an overflow pulse.
- R9: The external clear level clears the count in every mode. Clears win over a count step in the same cycle, and coincident clear causes give a single clear to zero.
- R10: While enable is low, the count holds and neither pulse is produced.
- R11: The flag-clear input clears both sticky flags on the next edge. An overflow in the same cycle leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; rising edge starts a run |
| mode_i | input | 3 | Mode code (0 free, 1 pulse width, 2 event, 3 encoder, 4 triangle) |
| cmp_i | input | 16 | Compare value |
| cmp_clr_en_i | input | 1 | Enable clear on compare match |
| reload_i | input | 16 | Encoder start value |
| load_sel_i | input | 1 | 0: load reload value at start in encoder mode |
| evt_i | input | 1 | Event strobe |
| enc_up_i | input | 1 | Encoder up strobe |
| enc_dn_i | input | 1 | Encoder down strobe |
| enc_clr_i | input | 1 | Encoder clear strobe |
| cap_i | input | 1 | Capture strobe |
| clr_lvl_i | input | 1 | External clear level |
| flag_clr_i | input | 1 | Clear sticky flags |
| cnt_o | output | 16 | Counter value |
| cap_o | output | 16 | Captured value |
| match_o | output | 1 | Compare-match clear pulse |
| ovf_o | output | 1 | Overflow pulse |
| ovf_flag_o | output | 1 | Sticky general overflow flag |
| enc_ovf_flag_o | output | 1 | Sticky encoder overflow flag |

## Verification
The assertions check the following on every cycle: any clear gives a zero count, a low enable freezes the count and masks both pulses, the match and overflow pulses never occur together, triangular mode never overflows, the event count holds without a strobe, and the flags are sticky. The bench scenarios are needed to show the count sequences, which are the 0xFFFF start, the triangular turnarounds, the encoder reload choice and the captured values. They are also needed for the overflow suppressions: on the first step after a start, on a compare clear at 0xFFFF, and on a capture of 0xFFFF. A free-running pass over the full 16-bit range shows that the general flag is set only after a complete wrap.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [2:0] MODE_FREE = 3'd0;
  localparam logic [2:0] MODE_PW   = 3'd1;
  localparam logic [2:0] MODE_EVT  = 3'd2;
  localparam logic [2:0] MODE_ENC  = 3'd3;
  localparam logic [2:0] MODE_TRI  = 3'd4;

  function automatic logic ovf_mode(input logic [2:0] m);
    return (m != MODE_EVT) && (m != MODE_TRI);
  endfunction
endpackage

// File: rtl/tmr16_clr.sv
module tmr16_clr
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         cmp_en_i,
  input  logic         cap_i,
  input  logic         enc_clr_i,
  input  logic         lvl_i,
  output logic         cmp_hit_o,
  output logic         cap_take_o,
  output logic         clr_o
);
  logic cmp_mode;
  assign cmp_mode   = (mode_i != MODE_PW) && (mode_i != MODE_TRI);
  assign cmp_hit_o  = cmp_en_i && cmp_mode && (cnt_i == cmp_i);
  assign cap_take_o = cap_i && (mode_i == MODE_PW);
  // all causes merge into one clear
  assign clr_o = lvl_i || cmp_hit_o || cap_take_o ||
                 (enc_clr_i && (mode_i == MODE_ENC));
endmodule

// File: rtl/tmr16_step.sv
module tmr16_step
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         dir_i,
  input  logic         evt_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic         step_o,
  output logic         up_o,
  output logic         dir_o,
  output logic [W-1:0] nxt_o
);
  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    dir_o  = dir_i;
    unique case (mode_i)
      MODE_EVT: step_o = evt_i;
      MODE_ENC: begin
        step_o = up_i ^ dn_i;
        up_o   = up_i;
      end
      MODE_TRI: begin
        step_o = 1'b1;
        if (dir_i) begin
          if (cnt_i == '0) dir_o = 1'b0;
          else             up_o  = 1'b0;
        end else if (cnt_i == cmp_i) begin
          dir_o = 1'b1;
          up_o  = 1'b0;
        end
      end
      default: step_o = 1'b1;
    endcase
    nxt_o = up_o ? cnt_i + 1'b1 : cnt_i - 1'b1;
  end
endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_evt_i,
  input  logic enc_mode_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic gen_o,
  output logic enc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      gen_o <= 1'b0;
      enc_o <= 1'b0;
    end else begin
      ovf_o <= ovf_evt_i;
      // set wins over clear
      gen_o <= (gen_o && !clr_i) || (ovf_evt_i && !enc_mode_i);
      enc_o <= (enc_o && !clr_i) || (ovf_evt_i && enc_mode_i);
    end
  end

  p_ovf_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (gen_o || enc_o));
  p_sticky_gen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_o && !clr_i) |=> gen_o);
  p_sticky_enc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_o && !clr_i) |=> enc_o);
endmodule

// File: rtl/multimode_tmr16.sv
module multimode_tmr16
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] cmp_i,
  input  logic         cmp_clr_en_i,
  input  logic [W-1:0] reload_i,
  input  logic         load_sel_i,
  input  logic         evt_i,
  input  logic         enc_up_i,
  input  logic         enc_dn_i,
  input  logic         enc_clr_i,
  input  logic         cap_i,
  input  logic         clr_lvl_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         match_o,
  output logic         ovf_o,
  output logic         ovf_flag_o,
  output logic         enc_ovf_flag_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cap_q, nxt, start_val;
  logic en_q, first_q, dir_q, match_q;
  logic start, run, clr, cmp_hit, cap_take, step, up, dir_n, ovf_evt;

  assign start = en_i && !en_q;
  assign run   = en_i && en_q;

  tmr16_clr #(.W(W)) u_clr (
    .mode_i(mode_i), .cnt_i(cnt_q), .cmp_i(cmp_i), .cmp_en_i(cmp_clr_en_i),
    .cap_i(cap_i), .enc_clr_i(enc_clr_i), .lvl_i(clr_lvl_i),
    .cmp_hit_o(cmp_hit), .cap_take_o(cap_take), .clr_o(clr)
  );

  tmr16_step #(.W(W)) u_step (
    .mode_i(mode_i), .cnt_i(cnt_q), .cmp_i(cmp_i), .dir_i(dir_q),
    .evt_i(evt_i), .up_i(enc_up_i), .dn_i(enc_dn_i),
    .step_o(step), .up_o(up), .dir_o(dir_n), .nxt_o(nxt)
  );

  always_comb begin
    unique case (mode_i)
      MODE_EVT: start_val = '0;
      MODE_ENC: start_val = load_sel_i ? cnt_q : reload_i;
      default:  start_val = CNT_MAX;
    endcase
  end

  // wrap is an overflow only once the run has left its first step
  assign ovf_evt = run && !clr && step && up && (cnt_q == CNT_MAX) &&
                   !first_q && ovf_mode(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cap_q   <= '0;
      en_q    <= 1'b0;
      first_q <= 1'b0;
      dir_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      en_q    <= en_i;
      match_q <= 1'b0;
      if (start) begin
        cnt_q   <= start_val;
        first_q <= 1'b1;
        dir_q   <= 1'b0;
      end else if (run) begin
        if (cap_take) cap_q <= cnt_q;
        if (clr) begin
          cnt_q   <= '0;
          first_q <= 1'b0;
          dir_q   <= 1'b0;
          match_q <= cmp_hit;
        end else if (step) begin
          cnt_q   <= nxt;
          dir_q   <= dir_n;
          first_q <= 1'b0;
        end
      end
    end
  end

  tmr16_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .ovf_evt_i(ovf_evt),
    .enc_mode_i(mode_i == MODE_ENC), .clr_i(flag_clr_i),
    .ovf_o(ovf_o), .gen_o(ovf_flag_o), .enc_o(enc_ovf_flag_o)
  );

  assign cnt_o   = cnt_q;
  assign cap_o   = cap_q;
  assign match_o = match_q;

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && clr) |=> (cnt_o == '0));
  p_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_o) && !ovf_o && !match_o));
  p_start_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && (mode_i == MODE_FREE)) |=> (cnt_o == CNT_MAX));
  p_pulse_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && match_o));
  p_tri_no_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TRI) |=> !ovf_o);
  p_evt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && (mode_i == MODE_EVT) && !evt_i && !clr) |=> $stable(cnt_o));
endmodule

// File: tb/multimode_tmr16_bench.sv
`timescale 1ns/1ps
module multimode_tmr16_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, cen = 0, lsel = 0, evt = 0, up = 0, dn = 0;
  logic eclr = 0, cap = 0, lvl = 0, fclr = 0;
  logic [2:0] mode = 0;
  logic [15:0] cmp = 0, rld = 0;
  logic [15:0] cnt_o, cap_o;
  logic match_o, ovf_o, gf_o, ef_o;

  // model state
  logic [15:0] m_cnt = 0, m_cap = 0;
  logic m_en = 0, m_first = 0, m_dir = 0, m_match = 0, m_ovf = 0, m_gf = 0, m_ef = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  multimode_tmr16 u_multimode_tmr16 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .cmp_i(cmp),
    .cmp_clr_en_i(cen), .reload_i(rld), .load_sel_i(lsel), .evt_i(evt),
    .enc_up_i(up), .enc_dn_i(dn), .enc_clr_i(eclr), .cap_i(cap),
    .clr_lvl_i(lvl), .flag_clr_i(fclr), .cnt_o(cnt_o), .cap_o(cap_o),
    .match_o(match_o), .ovf_o(ovf_o), .ovf_flag_o(gf_o), .enc_ovf_flag_o(ef_o)
  );

  task automatic chk(input string tag, input string nm, input logic [15:0] a, input logic [15:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, a, e);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "cnt", cnt_o, m_cnt);
    chk(tag, "cap", cap_o, m_cap);
    chk(tag, "match", {15'd0, match_o}, {15'd0, m_match});
    chk(tag, "ovf", {15'd0, ovf_o}, {15'd0, m_ovf});
    chk(tag, "gflag", {15'd0, gf_o}, {15'd0, m_gf});
    chk(tag, "eflag", {15'd0, ef_o}, {15'd0, m_ef});
  endtask

  function automatic logic in_ovf_mode(input logic [2:0] m);
    return m != 3'd2 && m != 3'd4;
  endfunction

  task automatic model();
    logic run, clr, hit, stp, u, ov;
    run = en && m_en;
    ov = 0;
    m_match = 0;
    if (en && !m_en) begin
      m_cnt = (mode == 3'd2) ? 16'h0 : (mode == 3'd3) ? (lsel ? m_cnt : rld) : 16'hFFFF;
      m_first = 1;
      m_dir = 0;
    end else if (run) begin
      if (mode == 3'd1 && cap) m_cap = m_cnt;
      hit = cen && m_cnt == cmp && mode != 3'd1 && mode != 3'd4;
      clr = lvl || hit || (mode == 3'd1 && cap) || (mode == 3'd3 && eclr);
      if (clr) begin
        m_cnt = 0; m_first = 0; m_dir = 0; m_match = hit;
      end else begin
        stp = 1; u = 1;
        case (mode)
          3'd2: stp = evt;
          3'd3: begin stp = up ^ dn; u = up; end
          3'd4: if (m_dir) begin
                  if (m_cnt == 0) m_dir = 0; else u = 0;
                end else if (m_cnt == cmp) begin
                  m_dir = 1; u = 0;
                end
          default: ;
        endcase
        if (stp) begin
          if (u && m_cnt == 16'hFFFF && !m_first && in_ovf_mode(mode)) ov = 1;
          m_cnt = u ? m_cnt + 16'd1 : m_cnt - 16'd1;
          m_first = 0;
        end
      end
    end
    if (fclr) begin m_gf = 0; m_ef = 0; end
    if (ov && mode == 3'd3) m_ef = 1;
    else if (ov) m_gf = 1;
    m_ovf = ov;
    m_en = en;
  endtask

  task automatic tick(input string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    en = 0; evt = 0; up = 0; dn = 0; eclr = 0; cap = 0; lvl = 0; fclr = 0; cen = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // R4: compare clear at 0xFFFF right after start, no overflow
    mode = 3'd0; cmp = 16'hFFFF; cen = 1; en = 1;
    tick("R2"); tick("R4"); tick("R4"); cen = 0; tick("R4");
    idle(); tick("R10"); tick("R10");

    // R5: capture of 0xFFFF
    mode = 3'd1; en = 1; tick("R2");
    cap = 1; tick("R5"); cap = 0; tick("R5"); tick("R5");
    idle(); tick("R10");

    // R7/R3: encoder reload near max, overflow on encoder flag
    mode = 3'd3; rld = 16'hFFFE; lsel = 0; en = 1; tick("R7");
    up = 1; tick("R7"); tick("R3"); tick("R3");
    up = 1; dn = 1; tick("R7"); up = 0; tick("R7");
    dn = 0; eclr = 1; tick("R7"); eclr = 0;
    fclr = 1; up = 1; tick("R11"); fclr = 0; up = 0; tick("R11");
    idle(); lsel = 1; rld = 16'h1234; tick("R10");
    mode = 3'd3; en = 1; tick("R7"); idle(); tick("R10");

    // R6: event count
    mode = 3'd2; en = 1; tick("R6");
    for (int i = 0; i < 6; i++) begin evt = i[0]; tick("R6"); end
    lvl = 1; evt = 1; tick("R9"); lvl = 0; evt = 0; tick("R9");
    idle(); tick("R10");

    // R8: triangle
    mode = 3'd4; cmp = 16'd3; en = 1; tick("R8");
    for (int i = 0; i < 12; i++) tick("R8");
    idle(); tick("R10");

    // R3: full free-running wrap sets general flag
    mode = 3'd0; en = 1; tick("R2");
    for (int i = 0; i < 65540; i++) tick("R3");
    fclr = 1; tick("R11"); fclr = 0; tick("R11");
    idle(); tick("R10");

    // randomized mixture
    void'($urandom(32'd1357));
    for (int b = 0; b < 40; b++) begin
      idle();
      tick("R10");
      mode = 3'($urandom % 5);
      cmp = (mode == 3'd4) ? 16'($urandom % 40 + 1) : 16'($urandom % 40);
      cen = ($urandom % 2) == 0;
      lsel = ($urandom % 2) == 0;
      rld = (($urandom % 2) == 0) ? 16'($urandom) : 16'hFFF0 + 16'($urandom % 16);
      case (mode)
        3'd0: tg = "R2";
        3'd1: tg = "R5";
        3'd2: tg = "R6";
        3'd3: tg = "R7";
        default: tg = "R8";
      endcase
      en = 1;
      for (int c = 0; c < 100; c++) begin
        evt  = ($urandom % 2) == 0;
        up   = ($urandom % 2) == 0;
        dn   = ($urandom % 3) == 0;
        eclr = ($urandom % 32) == 0;
        cap  = ($urandom % 16) == 0;
        lvl  = ($urandom % 64) == 0;
        fclr = ($urandom % 32) == 0;
        en   = ($urandom % 50) != 0;
        tick(tg);
      end
    end
    finish_run();
  end
endmodule